// File: doc/BRIEF.md
# Scan Chain Test Sequencer

This block wraps a bank of N storage bits that sits between a front combinational stage and the block's parallel output. Every bit has a two-way input select. With the scan enable high, the bit takes the value of its neighbour in the chain, so the whole bank forms one serial path from `scan_in` to `scan_out`. With the scan enable low, the bit takes the front stage's result. The front stage is a fixed mixing function of the parallel input.

A built-in sequencer runs a complete test on a single `start` strobe. It shifts a pattern in over N cycles and runs one capture cycle with the scan enable low. It then shifts the captured response out over N cycles. The bits presented on `scan_in` during that shift-out phase fill the chain, and they become the pattern for the next test. Once a test has completed, a later `start` therefore skips the load phase and goes straight to capture. A one-cycle `done` pulse marks the cycle after the last response bit has left the chain.

Top module: `scan_test_wrap`

## Requirements
- R1: After a synchronous reset, every chain bit is 0, `par_out` and `scan_out` are 0, `scan_en` and `done` are low, and no previous test is remembered.
- R2: A `start` seen in idle with no completed test since reset raises `scan_en` for exactly N cycles. During those cycles one `scan_in` bit is shifted in per clock, and the first bit sent ends up in `par_out[N-1]`.
- R3: The chain order is `scan_in` into bit 0, bit i into bit i+1, and bit N-1 drives `scan_out`. `scan_out` and `par_out` are taken directly from the chain registers.
- R4: Exactly one capture cycle follows each load, with `scan_en` low. On that cycle bit i loads `par_in[i] XOR par_in[(i+N-1) mod N]`.
- R5: The shift-out phase lasts N cycles with `scan_en` high. On the first of them `scan_out` shows captured bit N-1, and on each later one it shows the next lower bit.
- R6: The `scan_in` bits presented during shift-out are loaded into the chain in the order of R2. They are what `par_out` shows once the test ends.
- R7: `done` is high for exactly one cycle, the cycle after the final shift-out clock. In that cycle `scan_en` is low.
- R8: A `start` that arrives while a test is running has no effect on the sequence, its timing or its results.
- R9: A `start` seen in idle after a completed test skips the load phase. The capture happens on the first clock after the strobe and uses the chain contents left by the last shift-out.
- R10: In idle without `start`, the chain holds its value, and changes on `par_in` do not reach `par_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that begins a test sequence |
| scan_in | input | 1 | Serial data into chain bit 0 |
| par_in | input | N | Functional parallel input to the front stage |
| scan_out | output | 1 | Serial data from chain bit N-1 |
| par_out | output | N | Chain contents, the functional parallel output |
| scan_en | output | 1 | High while the chain shifts |
| done | output | 1 | One-cycle pulse at the end of a test |

## Verification
The bench checks the capture cycle from both ends. A design with an extra or missing capture would misplace every response bit by one position on `scan_out`, and a wrong mix function would corrupt specific bits. It checks the boundary between the last load clock and the capture: an off-by-one counter would shift N-1 or N+1 bits and rotate the pattern seen on `par_out`. It also injects `start` strobes in the middle of load and shift-out phases, where a design that restarts would stretch the sequence and move `done`. It runs back-to-back tests that rely on the overlap. A design that forgot the completed test would load again, and one that dropped the overlapped bits would capture from the wrong chain state.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_LOAD    = 2'd1,
    SQ_CAPTURE = 2'd2,
    SQ_UNLOAD  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/scan_cell.sv
// One storage bit with a scan/functional input select.
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic sel_scan,
  input  logic scan_d,
  input  logic func_d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (en) begin
      q <= sel_scan ? scan_d : func_d;
    end
  end
endmodule

// File: rtl/scan_front_logic.sv
// Front combinational stage: each result bit mixes an input bit with its lower neighbour (wrapping).
module scan_front_logic #(
  parameter int N = 8
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_mix
    localparam int NB = (i + N - 1) % N;
    assign dout[i] = din[i] ^ din[NB];
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
// Sequencer: load N shifts, one capture, unload N shifts, done pulse.
module scan_seq_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic shift_en,
  output logic capture_en,
  output logic idle,
  output logic scan_en_q,
  output logic done_q
);
  import scan_pkg::*;

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  seq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic primed_q;
  logic last_bit;

  assign last_bit = (cnt_q == LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (start) st_d = primed_q ? SQ_CAPTURE : SQ_LOAD;
      end
      SQ_LOAD: begin
        if (last_bit) begin
          st_d  = SQ_CAPTURE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_CAPTURE: begin
        st_d  = SQ_UNLOAD;
        cnt_d = '0;
      end
      SQ_UNLOAD: begin
        if (last_bit) begin
          st_d  = SQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      primed_q  <= 1'b0;
      scan_en_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      scan_en_q <= (st_d == SQ_LOAD) || (st_d == SQ_UNLOAD);
      done_q    <= (st_q == SQ_UNLOAD) && last_bit;
      if ((st_q == SQ_UNLOAD) && last_bit) primed_q <= 1'b1;
    end
  end

  assign shift_en   = (st_q == SQ_LOAD) || (st_q == SQ_UNLOAD);
  assign capture_en = (st_q == SQ_CAPTURE);
  assign idle       = (st_q == SQ_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R7
  AST_DONE_NO_SCAN: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !scan_en_q); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R2
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_CAPTURE) |=> (st_q == SQ_UNLOAD)); // R4
  AST_CAPTURE_NO_SCAN: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_CAPTURE) |-> !scan_en_q); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    ((st_q == SQ_LOAD) && !last_bit && start) |=> ((st_q == SQ_LOAD) && (cnt_q == $past(cnt_q) + 1'b1))); // R8
  AST_IDLE_NO_SCAN: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_IDLE) |-> !scan_en_q); // R10
endmodule

// File: rtl/scan_test_wrap.sv
// Top: scan chain of N bits, front stage, sequencer.
module scan_test_wrap #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         scan_in,
  input  logic [N-1:0] par_in,
  output logic         scan_out,
  output logic [N-1:0] par_out,
  output logic         scan_en,
  output logic         done
);
  logic [N-1:0] front_q;
  logic [N-1:0] chain;
  logic [N:0]   link;
  logic shift_en, capture_en, idle;

  scan_front_logic #(.N(N)) u_front (
    .din  (par_in),
    .dout (front_q)
  );

  scan_seq_ctrl #(.N(N)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .idle       (idle),
    .scan_en_q  (scan_en),
    .done_q     (done)
  );

  assign link[0] = scan_in;
  for (genvar i = 0; i < N; i++) begin : g_chain
    scan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .en       (shift_en | capture_en),
      .sel_scan (shift_en),
      .scan_d   (link[i]),
      .func_d   (front_q[i]),
      .q        (chain[i])
    );
    assign link[i+1] = chain[i];
  end

  assign scan_out = link[N];
  assign par_out  = chain;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (par_out[0] == $past(scan_in))); // R3
  if (N > 1) begin : g_path_chk
    AST_SHIFT_PATH: assert property (@(posedge clk) disable iff (rst)
      scan_en |=> (scan_out == $past(par_out[N-2]))); // R3
  end
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
    capture_en |=> (par_out == $past(front_q))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> $stable(par_out)); // R10
endmodule

// File: tb/tb_scan_test_wrap.sv
module tb_scan_test_wrap;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, start, scan_in;
  logic [N-1:0] par_in;
  logic scan_out, scan_en, done;
  logic [N-1:0] par_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit primed = 0;
  logic [N-1:0] exp_chain;

  scan_test_wrap #(.N(N)) dut (
    .clk(clk), .rst(rst), .start(start), .scan_in(scan_in), .par_in(par_in),
    .scan_out(scan_out), .par_out(par_out), .scan_en(scan_en), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [N-1:0] front_fn(input logic [N-1:0] x);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = x[i] ^ x[(i + N - 1) % N];
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One full test. inject: pulse start in the middle of a running phase.
  task automatic run_test(input logic [N-1:0] pat, input logic [N-1:0] nxt,
                          input logic [N-1:0] pin, input bit inject);
    logic [N-1:0] cap;
    @(negedge clk);
    par_in = pin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!primed) begin
      for (int i = 0; i < N; i++) begin
        check("R2 scan_en in load", {{(N-1){1'b0}}, scan_en}, 1);
        scan_in = pat[N-1-i];
        start = (inject && i == 2);
        @(negedge clk);
      end
      start = 1'b0;
      check("R2 pattern loaded", par_out, pat);
      exp_chain = pat;
    end else begin
      check("R9 no load, chain kept", par_out, exp_chain);
    end
    check("R4 capture scan_en low", {{(N-1){1'b0}}, scan_en}, 0);
    @(negedge clk);
    cap = front_fn(pin);
    check("R4 captured response", par_out, cap);
    for (int k = 0; k < N; k++) begin
      check("R5 scan_out bit", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, cap[N-1-k]});
      check("R5 scan_en in unload", {{(N-1){1'b0}}, scan_en}, 1);
      check("R7 no early done", {{(N-1){1'b0}}, done}, 0);
      scan_in = nxt[N-1-k];
      start = (inject && k == 3);
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 done pulse", {{(N-1){1'b0}}, done}, 1);
    check("R7 scan_en low at done", {{(N-1){1'b0}}, scan_en}, 0);
    check("R6 next pattern in chain", par_out, nxt);
    exp_chain = nxt;
    primed = 1;
    @(negedge clk);
    check("R7 done one cycle", {{(N-1){1'b0}}, done}, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; scan_in = 1'b0; par_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 chain clear", par_out, '0);
    check("R1 scan_out", {{(N-1){1'b0}}, scan_out}, 0);
    check("R1 scan_en", {{(N-1){1'b0}}, scan_en}, 0);
    check("R1 done", {{(N-1){1'b0}}, done}, 0);

    // R10: idle, par_in toggles, no start
    par_in = 8'h5A;
    repeat (3) @(negedge clk);
    check("R10 idle hold", par_out, '0);

    // Directed corners
    run_test(8'h80, 8'h01, 8'h81, 0);   // R2 R3 first bit reaches MSB
    run_test(8'h00, 8'hFF, 8'h01, 1);   // R9 primed, R8 injected start
    par_in = 8'hC3;
    repeat (2) @(negedge clk);
    check("R10 idle hold after test", par_out, 8'hFF);

    // Fresh reset then load with mid-phase start strobes (R8)
    rst = 1'b1; @(negedge clk); rst = 1'b0; primed = 0;
    check("R1 reset clears chain", par_out, '0);
    run_test(8'hA5, 8'h3C, 8'hF0, 1);

    for (int t = 0; t < 20; t++) begin
      run_test(N'($urandom), N'($urandom), N'($urandom), ($urandom % 3) == 0);
      repeat ($urandom % 3) @(negedge clk);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule